// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block works out the 24-bit effective address of one instruction operand for a processor with a 16-bit direct-page base, an 8-bit data bank and two 16-bit index registers. A start pulse starts it, and it captures the addressing-mode code, the program address and the register context at that moment. It then fetches the operand bytes that follow the opcode and, for the indirect modes, the pointer bytes those operands name. The byte fetches go through a request/valid memory port that can take any number of cycles to answer. When the address is ready, the block asserts done for one cycle, together with the effective address and the program address advanced past the operand.

Bank-zero direct arithmetic wraps within 16 bits. Absolute and long indexed sums carry into the bank byte. The two relative modes sign-extend their offset. A mode code outside the supported range finishes straight away with an error flag and makes no memory access.

Top module: `addrGen`

## Requirements
- R1: After reset, done, memReq and modeErr are all low until a start is accepted.
- R2: Operand bytes are read little-endian from pcIn, pcIn+1 and pcIn+2, using a 24-bit wrapping increment. On done, pcOut equals pcIn plus the operand byte count. The count is 1 for codes 1-3, 9-13, and 2 for codes 4-6, 14-16, and 3 for codes 7-8.
- R3: memReq stays high with memAddr unchanged until memValid is seen in the same cycle. Each such cycle transfers one byte. memReq is low when the block is idle and in the done cycle.
- R4: Code 1 gives {8'h00, dirPage + op8}. Codes 2 and 3 add idxX and idxY respectively to that 16-bit sum, and the result wraps within 16 bits.
- R5: Code 4 gives {dataBank, op16}. Codes 5 and 6 add idxX and idxY to that 24-bit value, carrying into the bank. Code 7 gives op24, and code 8 gives op24 + idxX modulo 2^24.
- R6: Code 9 reads a 2-byte pointer at bank-zero addresses dirPage+op8 and the address after it (16-bit wrap), then gives {dataBank, pointer}. Code 10 adds idxY to that value over 24 bits.
- R7: Code 11 reads a 2-byte pointer at dirPage+op8+idxX (16-bit wrap) and gives {dataBank, pointer}. Code 12 reads 3 pointer bytes from dirPage+op8 onward and uses them as the whole address.
- R8: Code 13 gives pcIn plus the sign-extended 8-bit operand. Code 14 gives pcIn plus the sign-extended 16-bit operand. Both sums are taken modulo 2^24.
- R9: Code 15 reads a 2-byte pointer at bank-zero address op16 and gives {8'h00, pointer}. Code 16 does the same at op16 + idxX, wrapped to 16 bits.
- R10: Code 0 (immediate) makes no memory access and gives effAddr = pcIn and pcOut = pcIn + 1.
- R11: Codes 17 to 31 make no memory access. They finish with modeErr high for the done cycle only, effAddr = 0 and pcOut = pcIn.
- R12: done is a single-cycle pulse. A start pulse is ignored while a computation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a computation; sampled while idle |
| mode | input | 5 | Addressing-mode code |
| pcIn | input | 24 | Program address of the first operand byte |
| dirPage | input | 16 | Direct-page base |
| dataBank | input | 8 | Data bank |
| idxX | input | 16 | Index X |
| idxY | input | 16 | Index Y |
| memReq | output | 1 | Byte read request |
| memAddr | output | 24 | Byte read address |
| memRdata | input | 8 | Returned byte |
| memValid | input | 1 | Returned byte valid |
| done | output | 1 | Result valid pulse |
| effAddr | output | 24 | Effective address |
| pcOut | output | 24 | Program address after the operand |
| modeErr | output | 1 | Unsupported mode, valid with done |

## Verification
The sweep runs every code under contexts chosen to provoke each wrap:
- A direct base near 16'hFFFF makes a design that lets the direct sum spill into bit 16 produce a nonzero bank.
- Index values of 16'hFFFF combined with bank 8'hFF catch a design that clips the absolute indexed sum to 16 bits, because the bank byte then fails to advance or wrap.
- Program addresses at 24'h12FFFF and 24'hFFFFFE catch operand fetches that wrap inside a bank instead of crossing it.
- The relative modes catch a missing sign extension, and responses with zero to two wait cycles catch a design that moves memAddr or consumes a byte before memValid.

// File: rtl/addrGenPkg.sv
`timescale 1ns/1ps
package addrGenPkg;
  localparam int ADDR_W = 24;
  localparam int IDX_W  = 16;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 5;
  localparam int MAX_BYTES = 3;
  localparam int IDX_CNT_W = $clog2(MAX_BYTES + 1);

  typedef enum logic [MODE_W-1:0] {
    M_IMM    = 5'd0,  M_DIR    = 5'd1,  M_DIR_X  = 5'd2,  M_DIR_Y  = 5'd3,
    M_ABS    = 5'd4,  M_ABS_X  = 5'd5,  M_ABS_Y  = 5'd6,  M_LONG   = 5'd7,
    M_LONG_X = 5'd8,  M_DIND   = 5'd9,  M_DIND_Y = 5'd10, M_DXIND  = 5'd11,
    M_DIND_L = 5'd12, M_REL8   = 5'd13, M_REL16  = 5'd14, M_AIND   = 5'd15,
    M_AXIND  = 5'd16
  } modeT;

  typedef struct packed {
    logic                 loadCtx;
    logic                 takeOp;
    logic                 takePtr;
    logic                 ptrPhase;
    logic [IDX_CNT_W-1:0] byteIdx;
  } strobeT;

  function automatic logic modeValid(input logic [MODE_W-1:0] m);
    return m <= M_AXIND;
  endfunction

  function automatic logic [IDX_CNT_W-1:0] opCount(input logic [MODE_W-1:0] m);
    case (m)
      M_IMM:                                   return 2'd0;
      M_ABS, M_ABS_X, M_ABS_Y, M_REL16,
      M_AIND, M_AXIND:                         return 2'd2;
      M_LONG, M_LONG_X:                        return 2'd3;
      default:                                 return modeValid(m) ? 2'd1 : 2'd0;
    endcase
  endfunction

  function automatic logic [IDX_CNT_W-1:0] ptrCount(input logic [MODE_W-1:0] m);
    case (m)
      M_DIND, M_DIND_Y, M_DXIND, M_AIND, M_AXIND: return 2'd2;
      M_DIND_L:                                   return 2'd3;
      default:                                    return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/addrGenCtrl.sv
`timescale 1ns/1ps
module addrGenCtrl
  import addrGenPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic              memValid,
  output logic              memReq,
  output strobeT            strb,
  output logic [MODE_W-1:0] modeQ,
  output logic              done,
  output logic              errFlag
);
  typedef enum logic [1:0] {S_IDLE, S_OPER, S_PTR, S_FIN} stateT;

  stateT                state;
  logic [IDX_CNT_W-1:0] idx;
  logic [MODE_W-1:0]    modeReg;
  logic                 errReg;

  always_comb begin
    strb          = '0;
    strb.byteIdx  = idx;
    strb.ptrPhase = (state == S_PTR);
    strb.loadCtx  = (state == S_IDLE) && start;
    strb.takeOp   = (state == S_OPER) && memValid;
    strb.takePtr  = (state == S_PTR) && memValid;
  end

  assign memReq  = (state == S_OPER) || (state == S_PTR);
  assign done    = (state == S_FIN);
  assign modeQ   = modeReg;
  assign errFlag = errReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      idx     <= '0;
      modeReg <= '0;
      errReg  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          modeReg <= mode;
          errReg  <= !modeValid(mode);
          idx     <= '0;
          state   <= (opCount(mode) == '0) ? S_FIN : S_OPER;
        end
        S_OPER: if (memValid) begin
          if (idx == opCount(modeReg) - 2'd1) begin
            idx   <= '0;
            state <= (ptrCount(modeReg) != '0) ? S_PTR : S_FIN;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        S_PTR: if (memValid) begin
          if (idx == ptrCount(modeReg) - 2'd1) begin
            idx   <= '0;
            state <= S_FIN;
          end else begin
            idx <= idx + 2'd1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/addrGenPath.sv
`timescale 1ns/1ps
module addrGenPath
  import addrGenPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [MODE_W-1:0] modeQ,
  input  logic              errFlag,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [IDX_W-1:0]  dirPage,
  input  logic [BYTE_W-1:0] dataBank,
  input  logic [IDX_W-1:0]  idxX,
  input  logic [IDX_W-1:0]  idxY,
  input  logic [BYTE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] pcOut
);
  localparam int BANK_PAD = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] pcStart, pcCur, opReg, ptrReg;
  logic [IDX_W-1:0]  dReg, xReg, yReg;
  logic [BYTE_W-1:0] bankReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcStart <= '0;
      pcCur   <= '0;
      opReg   <= '0;
      ptrReg  <= '0;
      dReg    <= '0;
      xReg    <= '0;
      yReg    <= '0;
      bankReg <= '0;
    end else if (strb.loadCtx) begin
      pcStart <= pcIn;
      pcCur   <= pcIn;
      opReg   <= '0;
      ptrReg  <= '0;
      dReg    <= dirPage;
      xReg    <= idxX;
      yReg    <= idxY;
      bankReg <= dataBank;
    end else begin
      if (strb.takeOp) pcCur <= pcCur + 24'd1;
      for (int b = 0; b < MAX_BYTES; b++) begin
        if (strb.takeOp && strb.byteIdx == b[IDX_CNT_W-1:0])
          opReg[b*BYTE_W +: BYTE_W] <= memRdata;
        if (strb.takePtr && strb.byteIdx == b[IDX_CNT_W-1:0])
          ptrReg[b*BYTE_W +: BYTE_W] <= memRdata;
      end
    end
  end

  logic [IDX_W-1:0]  dirBase, ptrBase;
  logic [ADDR_W-1:0] absFull, bankPtr, xWide, yWide, result;

  assign dirBase = dReg + {8'h00, opReg[7:0]};
  assign absFull = {bankReg, opReg[15:0]};
  assign bankPtr = {bankReg, ptrReg[15:0]};
  assign xWide   = {{BANK_PAD{1'b0}}, xReg};
  assign yWide   = {{BANK_PAD{1'b0}}, yReg};

  always_comb begin
    case (modeQ)
      M_DXIND: ptrBase = dirBase + xReg;
      M_AIND:  ptrBase = opReg[15:0];
      M_AXIND: ptrBase = opReg[15:0] + xReg;
      default: ptrBase = dirBase;
    endcase
  end

  assign memAddr = strb.ptrPhase
                 ? {{BANK_PAD{1'b0}}, ptrBase + {{(IDX_W-IDX_CNT_W){1'b0}}, strb.byteIdx}}
                 : pcCur;

  always_comb begin
    case (modeQ)
      M_IMM:    result = pcStart;
      M_DIR:    result = {{BANK_PAD{1'b0}}, dirBase};
      M_DIR_X:  result = {{BANK_PAD{1'b0}}, dirBase + xReg};
      M_DIR_Y:  result = {{BANK_PAD{1'b0}}, dirBase + yReg};
      M_ABS:    result = absFull;
      M_ABS_X:  result = absFull + xWide;
      M_ABS_Y:  result = absFull + yWide;
      M_LONG:   result = opReg;
      M_LONG_X: result = opReg + xWide;
      M_DIND:   result = bankPtr;
      M_DIND_Y: result = bankPtr + yWide;
      M_DXIND:  result = bankPtr;
      M_DIND_L: result = ptrReg;
      M_REL8:   result = pcStart + {{(ADDR_W-8){opReg[7]}}, opReg[7:0]};
      M_REL16:  result = pcStart + {{(ADDR_W-16){opReg[15]}}, opReg[15:0]};
      M_AIND:   result = {{BANK_PAD{1'b0}}, ptrReg[15:0]};
      M_AXIND:  result = {{BANK_PAD{1'b0}}, ptrReg[15:0]};
      default:  result = '0;
    endcase
  end

  assign effAddr = errFlag ? '0 : result;
  assign pcOut   = pcCur + {{(ADDR_W-1){1'b0}}, (modeQ == M_IMM) && !errFlag};
endmodule

// File: rtl/addrGen.sv
`timescale 1ns/1ps
module addrGen
  import addrGenPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [IDX_W-1:0]  dirPage,
  input  logic [BYTE_W-1:0] dataBank,
  input  logic [IDX_W-1:0]  idxX,
  input  logic [IDX_W-1:0]  idxY,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [BYTE_W-1:0] memRdata,
  input  logic              memValid,
  output logic              done,
  output logic [ADDR_W-1:0] effAddr,
  output logic [ADDR_W-1:0] pcOut,
  output logic              modeErr
);
  strobeT            strb;
  logic [MODE_W-1:0] modeQ;
  logic              errFlag;

  addrGenCtrl ctrl (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .memValid(memValid),
    .memReq(memReq), .strb(strb), .modeQ(modeQ), .done(done), .errFlag(errFlag)
  );

  addrGenPath path (
    .clk(clk), .rstN(rstN), .strb(strb), .modeQ(modeQ), .errFlag(errFlag),
    .pcIn(pcIn), .dirPage(dirPage), .dataBank(dataBank), .idxX(idxX), .idxY(idxY),
    .memRdata(memRdata), .memAddr(memAddr), .effAddr(effAddr), .pcOut(pcOut)
  );

  assign modeErr = done && errFlag;
endmodule

// File: rtl/addrGenChecker.sv
`timescale 1ns/1ps
module addrGenChecker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        memReq,
  input logic        memValid,
  input logic [23:0] memAddr,
  input logic        done,
  input logic        modeErr
);
  logic       busyT;
  logic [2:0] readsSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyT     <= 1'b0;
      readsSeen <= '0;
    end else begin
      if (!busyT && start) begin
        busyT     <= 1'b1;
        readsSeen <= '0;
      end else begin
        if (done) busyT <= 1'b0;
        if (memReq && memValid) readsSeen <= readsSeen + 3'd1;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memAddr)); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busyT |-> !memReq); // R3
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memReq); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R12
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    modeErr |-> done); // R11
  AST_ERR_NO_READ: assert property (@(posedge clk) disable iff (!rstN)
    done && modeErr |-> readsSeen == 3'd0); // R11
  AST_READ_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    readsSeen <= 3'd6); // R2
endmodule

bind addrGen addrGenChecker chk (
  .clk(clk), .rstN(rstN), .start(start), .memReq(memReq), .memValid(memValid),
  .memAddr(memAddr), .done(done), .modeErr(modeErr)
);

// File: tb/addrGen_test.sv
`timescale 1ns/1ps
module addrGen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  mode = '0;
  logic [23:0] pcIn = '0;
  logic [15:0] dirPage = '0;
  logic [7:0]  dataBank = '0;
  logic [15:0] idxX = '0;
  logic [15:0] idxY = '0;
  logic        memReq;
  logic [23:0] memAddr;
  logic [7:0]  memRdata = '0;
  logic        memValid = 1'b0;
  logic        done;
  logic [23:0] effAddr;
  logic [23:0] pcOut;
  logic        modeErr;

  int total = 0;
  int failed = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  addrGen uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] mb(input logic [23:0] a);
    return (a[7:0] * 8'd7) ^ (a[15:8] * 8'd3) ^ a[23:16] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] zb(input logic [15:0] a);
    return mb({8'h00, a});
  endfunction

  task automatic model(input logic [4:0] m, input logic [23:0] pc, input logic [15:0] d,
                       input logic [7:0] bk, input logic [15:0] x, input logic [15:0] y,
                       output logic [23:0] ea, output logic [23:0] pco,
                       output int nrd, output bit err, output string req);
    logic [7:0]  o0, o1, o2;
    logic [15:0] op16, dir, pa, p16;
    logic [23:0] op24;
    int nop;
    o0 = mb(pc); o1 = mb(pc + 24'd1); o2 = mb(pc + 24'd2);
    op16 = {o1, o0}; op24 = {o2, o1, o0};
    dir = d + {8'h00, o0};
    err = 0; nop = 0; nrd = 0; ea = '0;
    case (m)
      5'd0:  begin ea = pc; req = "R10"; end
      5'd1:  begin ea = {8'h00, dir}; nop = 1; req = "R4"; end
      5'd2:  begin pa = dir + x; ea = {8'h00, pa}; nop = 1; req = "R4"; end
      5'd3:  begin pa = dir + y; ea = {8'h00, pa}; nop = 1; req = "R4"; end
      5'd4:  begin ea = {bk, op16}; nop = 2; req = "R5"; end
      5'd5:  begin ea = {bk, op16} + {8'h00, x}; nop = 2; req = "R5"; end
      5'd6:  begin ea = {bk, op16} + {8'h00, y}; nop = 2; req = "R5"; end
      5'd7:  begin ea = op24; nop = 3; req = "R5"; end
      5'd8:  begin ea = op24 + {8'h00, x}; nop = 3; req = "R5"; end
      5'd9:  begin p16 = {zb(dir + 16'd1), zb(dir)}; ea = {bk, p16}; nop = 1; nrd = 2; req = "R6"; end
      5'd10: begin p16 = {zb(dir + 16'd1), zb(dir)}; ea = {bk, p16} + {8'h00, y}; nop = 1; nrd = 2; req = "R6"; end
      5'd11: begin pa = dir + x; p16 = {zb(pa + 16'd1), zb(pa)}; ea = {bk, p16}; nop = 1; nrd = 2; req = "R7"; end
      5'd12: begin ea = {zb(dir + 16'd2), zb(dir + 16'd1), zb(dir)}; nop = 1; nrd = 3; req = "R7"; end
      5'd13: begin ea = pc + {{16{o0[7]}}, o0}; nop = 1; req = "R8"; end
      5'd14: begin ea = pc + {{8{op16[15]}}, op16}; nop = 2; req = "R8"; end
      5'd15: begin p16 = {zb(op16 + 16'd1), zb(op16)}; ea = {8'h00, p16}; nop = 2; nrd = 2; req = "R9"; end
      5'd16: begin pa = op16 + x; p16 = {zb(pa + 16'd1), zb(pa)}; ea = {8'h00, p16}; nop = 2; nrd = 2; req = "R9"; end
      default: begin err = 1; req = "R11"; end
    endcase
    nrd = nrd + nop;
    pco = (m == 5'd0) ? pc + 24'd1 : pc + 24'(nop);
  endtask

  task automatic runOne(input logic [4:0] m, input logic [23:0] pc, input logic [15:0] d,
                        input logic [7:0] bk, input logic [15:0] x, input logic [15:0] y,
                        input int lat, input bit poke);
    logic [23:0] expEa, expPc;
    int expRd, reads, waitCnt, iter;
    bit expErr;
    string req;
    model(m, pc, d, bk, x, y, expEa, expPc, expRd, expErr, req);
    reads = 0; waitCnt = 0; iter = 0;
    @(negedge clk);
    mode = m; pcIn = pc; dirPage = d; dataBank = bk; idxX = x; idxY = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    forever begin
      if (memValid) begin memValid = 1'b0; waitCnt = 0; end
      if (done) break;
      if (poke && iter == 1) begin start = 1'b1; mode = 5'd0; pcIn = 24'h0; end
      if (poke && iter == 2) start = 1'b0;
      if (memReq) begin
        if (waitCnt >= lat) begin
          memValid = 1'b1; memRdata = mb(memAddr); reads++;
        end else waitCnt++;
      end
      iter++;
      if (iter > 200) begin
        check(0, req, "run timed out", 24'(iter), 24'd0);
        return;
      end
      @(negedge clk);
    end
    check(effAddr == expEa, poke ? "R12" : req, "effAddr", effAddr, expEa);
    check(pcOut == expPc, "R2", "pcOut", pcOut, expPc);
    check(modeErr == expErr, "R11", "modeErr", 24'(modeErr), 24'(expErr));
    check(reads == expRd, "R2", "read count", 24'(reads), 24'(expRd));
    @(negedge clk);
    check(done == 1'b0, "R12", "done pulse width", 24'(done), 24'd0);
  endtask

  task automatic ctx(input int i, output logic [23:0] pc, output logic [15:0] d,
                     output logic [7:0] bk, output logic [15:0] x, output logic [15:0] y);
    case (i)
      0: begin pc = 24'h000100; d = 16'h0000; bk = 8'h7E; x = 16'h0003; y = 16'h0010; end
      1: begin pc = 24'h12FFFF; d = 16'hFFF8; bk = 8'hFF; x = 16'hFFFF; y = 16'hFFFF; end
      2: begin pc = 24'hFFFFFE; d = 16'h1234; bk = 8'h01; x = 16'h8000; y = 16'h0001; end
      default: begin pc = 24'h3456F0; d = 16'hFF00; bk = 8'h80; x = 16'h00FF; y = 16'h7FFF; end
    endcase
  endtask

  initial begin
    logic [23:0] pc;
    logic [15:0] d, x, y;
    logic [7:0]  bk;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", "done in reset", 24'(done), 24'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R1", "done after reset", 24'(done), 24'd0);
    check(memReq == 1'b0, "R1", "memReq after reset", 24'(memReq), 24'd0);
    check(modeErr == 1'b0, "R1", "modeErr after reset", 24'(modeErr), 24'd0);
    for (int c = 0; c < 4; c++) begin
      ctx(c, pc, d, bk, x, y);
      for (int lat = 0; lat < 3; lat++)
        for (int m = 0; m < 17; m++)
          runOne(5'(m), pc, d, bk, x, y, lat, 1'b0);
      for (int m = 17; m < 32; m++)
        runOne(5'(m), pc, d, bk, x, y, c, 1'b0);
    end
    ctx(1, pc, d, bk, x, y);
    runOne(5'd15, pc, d, bk, x, y, 2, 1'b1);
    runOne(5'd12, pc, d, bk, x, y, 2, 1'b1);
    finished = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      total++; failed++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule